// File: doc/BRIEF.md
# Multi-channel DMA slot scheduler

This block picks which of sixteen DMA channels gets the next transfer slot on a single shared engine. Each channel can raise two kinds of request. A watermark request is the urgent one. A hungry request is the weak one and is only seen when no watermark request is pending. A channel takes part in arbitration only while its enable bit is set.

A mode input chooses the scheduling scheme:
- **Priority mode:** each channel's 4-bit level decides, and ties at the same level are broken by a rotating pointer.
- **Round-robin mode:** levels are ignored and the same pointer alone rotates service.

The winning channel is registered as a grant. The grant is presented both as an index and as a one-hot vector, and it stays fixed until the engine signals the end of the slot.

After a slot ends, the grant is released for one cycle. Arbitration then resolves on that idle cycle, and the next grant appears on the following edge. Whenever a grant is taken, the pointer moves to the channel after the one granted. This keeps equal-level channels, and all channels in round-robin mode, from starving.

Top module: `dma_slot_sched`

## Requirements
- R1: After reset, `grant_valid` is 0, `grant_onehot` is 0, `grant_idx` is 0 and the rotation pointer is 0.
- R2: Channel i is eligible only when `ch_enable[i]` is 1 and `wm_req[i]` or `hungry_req[i]` is 1. A disabled channel is never granted, and with nothing eligible no grant is made.
- R3: If any enabled channel has `wm_req` set, only enabled watermark requesters compete. Hungry requests compete only when no enabled watermark request exists. This holds in both modes.
- R4: With `prio_mode`=1, the competitor with the largest level wins. Channel i's level is `ch_prio[4*i+3:4*i]`, and 15 is the highest.
- R5: With `prio_mode`=1, among competitors at the highest level, the first one found scanning upward from the pointer (wrapping from 15 to 0) wins.
- R6: With `prio_mode`=0, levels are ignored. The first competitor scanning upward from the pointer, with wrap, wins.
- R7: Each time a grant is taken, the pointer becomes (granted index + 1) mod 16.
- R8: While `grant_valid` is 1, the grant keeps its index until `slot_done` is sampled 1, whatever the request inputs do. `grant_valid` is 0 in the cycle after that edge.
- R9: While `grant_valid` is 1, `grant_onehot` has exactly bit `grant_idx` set. Otherwise it is all zero.
- R10: When no grant is held and an eligible request is present at a clock edge, `grant_valid` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_mode | input | 1 | 1 = priority scheduling, 0 = round-robin |
| ch_enable | input | 16 | Per-channel enable mask |
| wm_req | input | 16 | Per-channel watermark request |
| hungry_req | input | 16 | Per-channel hungry request |
| ch_prio | input | 64 | Per-channel 4-bit level, channel i at bits 4i+3..4i |
| slot_done | input | 1 | Engine finished the current slot |
| grant_valid | output | 1 | A grant is held |
| grant_idx | output | 4 | Index of granted channel |
| grant_onehot | output | 16 | One-hot form of the grant |

## Verification
When no grant is held, a request present at a clock edge produces a grant one edge later. A `slot_done` sampled at an edge clears `grant_valid` one edge later, and the next grant follows one edge after that. The bench drives its inputs on the falling edge and samples on the falling edge that follows the relevant rising edge, so each result is read exactly one register stage after its cause. The hold checks leave `slot_done` low for several cycles while the requests change, and read the grant at each of those falling edges.

// File: rtl/dma_slot_sched.sv
module dma_slot_sched #(
  parameter int NCH = 16,
  parameter int PW  = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prio_mode,
  input  logic [NCH-1:0]     ch_enable,
  input  logic [NCH-1:0]     wm_req,
  input  logic [NCH-1:0]     hungry_req,
  input  logic [NCH*PW-1:0]  ch_prio,
  input  logic               slot_done,
  output logic               grant_valid,
  output logic [IW-1:0]      grant_idx,
  output logic [NCH-1:0]     grant_onehot
);

  logic [NCH-1:0] wm_m, hg_m, cand, top;
  logic [PW-1:0]  max_lvl;
  logic [IW-1:0]  ptr, pick_idx;
  logic           pick_found;

  assign wm_m = ch_enable & wm_req;
  assign hg_m = ch_enable & hungry_req;
  assign cand = (|wm_m) ? wm_m : hg_m;

  always_comb begin
    max_lvl = '0;
    for (int i = 0; i < NCH; i++)
      if (cand[i] && ch_prio[i*PW +: PW] > max_lvl)
        max_lvl = ch_prio[i*PW +: PW];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_top
    assign top[g] = cand[g] && (!prio_mode || ch_prio[g*PW +: PW] == max_lvl);
  end

  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NCH) j = j - NCH;
      if (!pick_found && top[j]) begin
        pick_found = 1'b1;
        pick_idx   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      ptr         <= '0;
    end else if (grant_valid) begin
      if (slot_done) grant_valid <= 1'b0;
    end else if (pick_found) begin
      grant_valid <= 1'b1;
      grant_idx   <= pick_idx;
      ptr         <= (int'(pick_idx) == NCH-1) ? '0 : pick_idx + 1'b1;
    end
  end

  assign grant_onehot = grant_valid ? (NCH'(1) << grant_idx) : '0;

endmodule

// File: rtl/dma_slot_sched_chk.sv
module dma_slot_sched_chk #(
  parameter int NCH = 16,
  parameter int PW  = 4,
  localparam int IW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ch_enable,
  input logic [NCH-1:0]    wm_req,
  input logic [NCH-1:0]    hungry_req,
  input logic              slot_done,
  input logic              grant_valid,
  input logic [IW-1:0]     grant_idx,
  input logic [NCH-1:0]    grant_onehot
);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (|grant_onehot)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !slot_done |=> grant_valid && $stable(grant_idx));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && slot_done |=> !grant_valid);

  p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> |(grant_onehot & $past(ch_enable & (wm_req | hungry_req))));

  p_wm_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) && $past(|(ch_enable & wm_req)) |-> |(grant_onehot & $past(ch_enable & wm_req)));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid && |(ch_enable & (wm_req | hungry_req)) |=> grant_valid);

endmodule

bind dma_slot_sched dma_slot_sched_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .wm_req(wm_req),
  .hungry_req(hungry_req), .slot_done(slot_done), .grant_valid(grant_valid),
  .grant_idx(grant_idx), .grant_onehot(grant_onehot)
);

// File: tb/tb_dma_slot_sched.sv
module tb_dma_slot_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prio_mode = 1'b1;
  logic [15:0] ch_enable = '0, wm_req = '0, hungry_req = '0;
  logic [63:0] ch_prio = '0;
  logic        slot_done = 1'b0;
  logic        grant_valid;
  logic [3:0]  grant_idx;
  logic [15:0] grant_onehot;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_slot_sched dut (.*);

  typedef struct packed {
    logic        mode;
    logic [15:0] en, wm, hg;
    logic [63:0] pr;
    logic        xv;
    logic [3:0]  xi;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    {1'b1, 16'hFFFF, 16'h0000, 16'h0000, 64'h0,                   1'b0, 4'd0},  // R2 none
    {1'b1, 16'hFFFF, 16'h0024, 16'h0000, 64'h0000_0000_0090_0300, 1'b1, 4'd5},  // R4
    {1'b1, 16'hFFFF, 16'h0000, 16'h8001, 64'h2000_0000_0000_0007, 1'b1, 4'd0},  // R4 hungry
    {1'b1, 16'hFFFF, 16'h0002, 16'h0100, 64'h0000_000F_0000_0010, 1'b1, 4'd1},  // R3
    {1'b1, 16'hFFFF, 16'h0203, 16'h0000, 64'h0000_0040_0000_0044, 1'b1, 4'd9},  // R5
    {1'b1, 16'hFFFF, 16'h1009, 16'h0000, 64'h0002_0000_0000_4004, 1'b1, 4'd0},  // R5 wrap
    {1'b1, 16'hFFF7, 16'h0048, 16'h0000, 64'h0000_0000_0100_F000, 1'b1, 4'd6},  // R2 masked
    {1'b1, 16'h0000, 16'hFFFF, 16'h0000, 64'h0,                   1'b0, 4'd0},  // R2 all off
    {1'b0, 16'hFFFF, 16'h0204, 16'h0000, 64'h0000_0000_0000_0F00, 1'b1, 4'd9},  // R6
    {1'b0, 16'hFFFF, 16'h0204, 16'h0000, 64'h0000_0000_0000_0F00, 1'b1, 4'd2},  // R6 wrap, R7
    {1'b0, 16'hFFFF, 16'h0002, 16'h0030, 64'h0,                   1'b1, 4'd1},  // R3 rr
    {1'b0, 16'hFFFF, 16'h0000, 16'h8005, 64'h0,                   1'b1, 4'd2},  // R7
    {1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 64'h0,                   1'b1, 4'd3}   // R5 R7
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic end_slot();
    slot_done = 1'b1;
    tick();
    slot_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(grant_valid), 0);
    check("R1 idx", 32'(grant_idx), 0);
    check("R1 onehot", 32'(grant_onehot), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      prio_mode = VEC[v].mode; ch_enable = VEC[v].en;
      wm_req = VEC[v].wm; hungry_req = VEC[v].hg; ch_prio = VEC[v].pr;
      tick();
      check($sformatf("R10 vec%0d valid", v), 32'(grant_valid), 32'(VEC[v].xv));
      if (VEC[v].xv) begin
        check($sformatf("R4-6 vec%0d idx", v), 32'(grant_idx), 32'(VEC[v].xi));
        check($sformatf("R9 vec%0d onehot", v), 32'(grant_onehot), 32'(16'd1 << VEC[v].xi));
      end else
        check($sformatf("R9 vec%0d onehot", v), 32'(grant_onehot), 0);
      end_slot();
      check($sformatf("R8 vec%0d released", v), 32'(grant_valid), 0);
    end

    // R8 hold: pointer is 4 here
    prio_mode = 1'b1; ch_enable = 16'hFFFF; hungry_req = '0;
    wm_req = 16'h0080; ch_prio = '0;
    tick();
    check("R8 first grant", 32'(grant_idx), 7);
    wm_req = 16'h0800; ch_prio = 64'h0000_F000_0000_0000;
    for (int c = 0; c < 5; c++) begin
      tick();
      check("R8 hold idx", 32'(grant_idx), 7);
      check("R8 hold valid", 32'(grant_valid), 1);
    end
    end_slot();
    check("R8 gap after slot_done", 32'(grant_valid), 0);
    tick();
    check("R8 next grant valid", 32'(grant_valid), 1);
    check("R8 next grant idx", 32'(grant_idx), 11);

    // R1 reset mid-slot clears grant and pointer
    rst_n = 1'b0;
    tick();
    check("R1 reset valid", 32'(grant_valid), 0);
    check("R1 reset onehot", 32'(grant_onehot), 0);
    wm_req = 16'hFFFF; ch_prio = '0;
    rst_n = 1'b1;
    tick();
    check("R1 r7_ pointer at 0", 32'(grant_idx), 0);
    end_slot();
    tick();
    check("R7 pointer advanced", 32'(grant_idx), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule